// File: doc/BRIEF.md
# Timer Interrupt Routing Unit

This block sits between a bank of timer channels and the interrupt inputs of a system. Each timer raises a one-cycle fire pulse when its comparator matches. The router decides which interrupt line that fire reaches and produces a clean single-cycle edge on that line. There are two delivery paths. The legacy-replacement path sends timer 0 and timer 1 to fixed ISA lines and also tells the legacy interval timer to stop raising its own channel-0 interrupt. The configurable path sends a fire to one input of an I/O interrupt controller, chosen by the timer's 5-bit route field.

A configurable route is accepted only when the timer's 32-bit capability mask has a bit set for that input number. The owner of the timer registers normally resets that mask to allow inputs 20 to 23 only. An illegal route, or a timer that is armed with level-type delivery selected, sets a sticky error flag and delivers nothing. Only edge delivery exists. Every output is registered, so an output responds one clock after the inputs that cause it.

Top module: `tmr_irq_router`

## Requirements
- R1: With `legacy_en` high, an armed, edge-type fire from timer 0 pulses `isa_pulse[0]` and one from timer 1 pulses `isa_pulse[8]`, one cycle after the fire. Their route fields are ignored and they produce no `ioin_pulse`.
- R2: `pit_ch0_mute` equals `legacy_en & tmr_armed[0]` as sampled on the previous clock edge.
- R3: Outside the legacy path, and always for timer 2, an armed, edge-type fire with a legal route `r` pulses `ioin_pulse[r]` one cycle later. Timer t's route is `tmr_route[5t+4:5t]`.
- R4: A route `r` is legal only if `r` < NUM_IOIN (24) and bit `r` of that timer's capability mask `tmr_cap[32t+31:32t]` is 1. For example, mask 0x00F00000 permits inputs 20 to 23 only.
- R5: An armed, edge-type fire on the configurable path with an illegal route pulses no line, and `route_err` is high from the next cycle.
- R6: A timer with `tmr_armed` and `tmr_level` both high sets `route_err` on the next cycle, whether or not it fires. A fire from such a timer is delivered on no line.
- R7: A fire from a timer whose `tmr_armed` bit is low has no effect. It produces no pulse and no error.
- R8: Fires from several timers in one cycle are delivered together in the same cycle. Fires aimed at the same line merge into one pulse.
- R9: No output line is high in two consecutive cycles. A request that arrives while its line is high is held and emitted in the cycle after the line has dropped, so it appears as a deassert followed by an assert.
- R10: `route_err` stays high until `err_clr` is asserted. A new error in the same cycle as `err_clr` keeps the flag set.
- R11: While `rst_n` is low, all outputs are low and any held requests are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| legacy_en | input | 1 | Global legacy-replacement select |
| tmr_route | input | NUM_TMR*ROUTE_W | Per-timer route field, timer t at [5t+4:5t] |
| tmr_cap | input | NUM_TMR*32 | Per-timer capability mask, timer t at [32t+31:32t] |
| tmr_armed | input | NUM_TMR | Per-timer enable |
| tmr_level | input | NUM_TMR | Per-timer level-type select (unsupported) |
| fire | input | NUM_TMR | One-cycle fire pulse per timer |
| err_clr | input | 1 | Clears the error flag |
| isa_pulse | output | ISA_LINES | Edge pulses to ISA lines |
| ioin_pulse | output | NUM_IOIN | Edge pulses to interrupt controller inputs |
| pit_ch0_mute | output | 1 | Tells the interval timer to silence channel 0 |
| route_err | output | 1 | Sticky routing error flag |

## Verification
The bench goes after several corner cases. Under legacy mode, timer 2 must still use its route field; a design that moved it to the legacy path would pulse an ISA line instead. A route of 24 or more with an all-ones mask must still be rejected; a design that checked only the mask would index past the input vector. A timer fired on two cycles in a row must give pulse, gap, pulse; a design that passed requests straight through would hold the line high and lose the edge. Two further cases cover a set and a clear of the error flag in the same cycle, and a level-type timer that is armed but idle; getting either wrong shows up as a flag that drops too early or never rises.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  // Fixed legacy targets; the line numbers are decoded by the legacy interrupt controller
  localparam int LEG_LINE_T0 = 0;
  localparam int LEG_LINE_T1 = 8;
  // Capability value normally loaded by the register owner at reset
  localparam logic [31:0] CAP_RESET = 32'h00F0_0000;

  typedef enum logic [1:0] {
    PATH_NONE   = 2'd0,
    PATH_LEGACY = 2'd1,
    PATH_IOIN   = 2'd2,
    PATH_FAULT  = 2'd3
  } path_e;
endpackage

// File: rtl/tmr_path_dec.sv
module tmr_path_dec
  import irq_route_pkg::*;
#(
  parameter int TIDX      = 0,
  parameter int ROUTE_W   = 5,
  parameter int NUM_IOIN  = 24,
  parameter int ISA_LINES = 16
) (
  input  logic                      legacy_en,
  input  logic [ROUTE_W-1:0]        route,
  input  logic [(1<<ROUTE_W)-1:0]   cap,
  input  logic                      armed,
  input  logic                      level,
  input  logic                      fire,
  output logic [ISA_LINES-1:0]      isa_req,
  output logic [NUM_IOIN-1:0]       io_req,
  output logic                      fault,
  output path_e                     path
);
  localparam bit HAS_LEG = (TIDX < 2);
  localparam int LEG_LINE = (TIDX == 0) ? LEG_LINE_T0 : LEG_LINE_T1;
  localparam logic [ROUTE_W:0] N_IN_L = (ROUTE_W+1)'(NUM_IOIN);

  function automatic logic route_legal(input logic [(1<<ROUTE_W)-1:0] c,
                                       input logic [ROUTE_W-1:0] r);
    return ({1'b0, r} < N_IN_L) && c[r];
  endfunction

  always_comb begin
    if (!(fire && armed))            path = PATH_NONE;
    else if (level)                  path = PATH_FAULT;
    else if (HAS_LEG && legacy_en)   path = PATH_LEGACY;
    else if (route_legal(cap, route)) path = PATH_IOIN;
    else                             path = PATH_FAULT;
  end

  always_comb begin
    isa_req = '0;
    if (path == PATH_LEGACY) isa_req[LEG_LINE] = 1'b1;
  end

  assign io_req = (path == PATH_IOIN) ? (NUM_IOIN'(1) << route) : '0;
  assign fault  = (armed && level) || (path == PATH_FAULT);
endmodule

// File: rtl/line_pulse_gen.sv
module line_pulse_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req,
  output logic [W-1:0] pulse
);
  logic [W-1:0] pend_q;
  logic [W-1:0] want;

  assign want = req | pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse  <= '0;
      pend_q <= '0;
    end else begin
      pulse  <= want & ~pulse;
      pend_q <= want & pulse;
    end
  end
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/tmr_irq_router.sv
module tmr_irq_router
  import irq_route_pkg::*;
#(
  parameter int NUM_TMR   = 3,
  parameter int ROUTE_W   = 5,
  parameter int NUM_IOIN  = 24,
  parameter int ISA_LINES = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          legacy_en,
  input  logic [NUM_TMR*ROUTE_W-1:0]    tmr_route,
  input  logic [NUM_TMR*(1<<ROUTE_W)-1:0] tmr_cap,
  input  logic [NUM_TMR-1:0]            tmr_armed,
  input  logic [NUM_TMR-1:0]            tmr_level,
  input  logic [NUM_TMR-1:0]            fire,
  input  logic                          err_clr,
  output logic [ISA_LINES-1:0]          isa_pulse,
  output logic [NUM_IOIN-1:0]           ioin_pulse,
  output logic                          pit_ch0_mute,
  output logic                          route_err
);
  localparam int CAP_W = 1 << ROUTE_W;

  logic [ISA_LINES-1:0] isa_req_t [NUM_TMR];
  logic [NUM_IOIN-1:0]  io_req_t  [NUM_TMR];
  logic [NUM_TMR-1:0]   fault_t;
  path_e                path_t    [NUM_TMR];

  // merged events, brought out for the checker
  logic [ISA_LINES-1:0] isa_req_all;
  logic [NUM_IOIN-1:0]  io_req_all;
  logic                 fault_any;

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    tmr_path_dec #(
      .TIDX(t), .ROUTE_W(ROUTE_W), .NUM_IOIN(NUM_IOIN), .ISA_LINES(ISA_LINES)
    ) u_dec (
      .legacy_en (legacy_en),
      .route     (tmr_route[t*ROUTE_W +: ROUTE_W]),
      .cap       (tmr_cap[t*CAP_W +: CAP_W]),
      .armed     (tmr_armed[t]),
      .level     (tmr_level[t]),
      .fire      (fire[t]),
      .isa_req   (isa_req_t[t]),
      .io_req    (io_req_t[t]),
      .fault     (fault_t[t]),
      .path      (path_t[t])
    );
  end

  always_comb begin
    isa_req_all = '0;
    io_req_all  = '0;
    for (int t = 0; t < NUM_TMR; t++) begin
      isa_req_all = isa_req_all | isa_req_t[t];
      io_req_all  = io_req_all  | io_req_t[t];
    end
  end
  assign fault_any = |fault_t;

  line_pulse_gen #(.W(ISA_LINES)) u_isa_pg (
    .clk(clk), .rst_n(rst_n), .req(isa_req_all), .pulse(isa_pulse)
  );

  line_pulse_gen #(.W(NUM_IOIN)) u_io_pg (
    .clk(clk), .rst_n(rst_n), .req(io_req_all), .pulse(ioin_pulse)
  );

  sticky_flag u_err (
    .clk(clk), .rst_n(rst_n), .set(fault_any), .clr(err_clr), .flag(route_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pit_ch0_mute <= 1'b0;
    else        pit_ch0_mute <= legacy_en && tmr_armed[0];
  end
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int NUM_TMR   = 3,
  parameter int NUM_IOIN  = 24,
  parameter int ISA_LINES = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 legacy_en,
  input logic [NUM_TMR-1:0]   tmr_armed,
  input logic                 err_clr,
  input logic [ISA_LINES-1:0] isa_req_all,
  input logic [NUM_IOIN-1:0]  io_req_all,
  input logic                 fault_any,
  input logic [ISA_LINES-1:0] isa_pulse,
  input logic [NUM_IOIN-1:0]  ioin_pulse,
  input logic                 pit_ch0_mute,
  input logic                 route_err
);
  p_legacy_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (isa_req_all[0] && !isa_pulse[0]) |=> isa_pulse[0]);

  p_mute_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy_en && tmr_armed[0]) |=> pit_ch0_mute);

  p_mute_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(legacy_en && tmr_armed[0]) |=> !pit_ch0_mute);

  p_io_deliver_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((io_req_all != '0) && (ioin_pulse == '0)) |=> (ioin_pulse != '0));

  p_err_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_any |=> route_err);

  p_io_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ioin_pulse != '0) |=> ((ioin_pulse & $past(ioin_pulse)) == '0));

  p_isa_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (isa_pulse != '0) |=> ((isa_pulse & $past(isa_pulse)) == '0));

  p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (route_err && !err_clr) |=> route_err);

  p_err_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !fault_any) |=> !route_err);
endmodule

bind tmr_irq_router irq_route_chk #(
  .NUM_TMR(NUM_TMR), .NUM_IOIN(NUM_IOIN), .ISA_LINES(ISA_LINES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .legacy_en(legacy_en), .tmr_armed(tmr_armed),
  .err_clr(err_clr), .isa_req_all(isa_req_all), .io_req_all(io_req_all),
  .fault_any(fault_any), .isa_pulse(isa_pulse), .ioin_pulse(ioin_pulse),
  .pit_ch0_mute(pit_ch0_mute), .route_err(route_err)
);

// File: tb/test_tmr_irq_router.sv
module test_tmr_irq_router;
  localparam int NT = 3;
  localparam int RW = 5;
  localparam int NI = 24;
  localparam int NL = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              legacy_en;
  logic [NT*RW-1:0]  tmr_route;
  logic [NT*32-1:0]  tmr_cap;
  logic [NT-1:0]     tmr_armed, tmr_level, fire;
  logic              err_clr;
  logic [NL-1:0]     isa_pulse;
  logic [NI-1:0]     ioin_pulse;
  logic              pit_ch0_mute, route_err;

  int n_chk = 0;
  int n_bad = 0;

  // reference state
  logic [NL-1:0] e_isa, p_isa;
  logic [NI-1:0] e_io,  p_io;
  logic          e_mute, e_err;

  tmr_irq_router i_tmr_irq_router (
    .clk(clk), .rst_n(rst_n), .legacy_en(legacy_en), .tmr_route(tmr_route),
    .tmr_cap(tmr_cap), .tmr_armed(tmr_armed), .tmr_level(tmr_level),
    .fire(fire), .err_clr(err_clr), .isa_pulse(isa_pulse),
    .ioin_pulse(ioin_pulse), .pit_ch0_mute(pit_ch0_mute), .route_err(route_err)
  );

  always #5 clk = ~clk;

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  function automatic logic [4:0] rt(input int t);
    return tmr_route[t*RW +: RW];
  endfunction

  // next-cycle requests, derived from the requirement text
  task automatic model_step();
    logic [NL-1:0] rq_isa = '0;
    logic [NI-1:0] rq_io  = '0;
    logic          bad    = 1'b0;
    for (int t = 0; t < NT; t++) begin
      if (tmr_armed[t] && tmr_level[t]) bad = 1'b1;                 // R6
      if (fire[t] && tmr_armed[t] && !tmr_level[t]) begin           // R7
        case ({legacy_en, t == 0, t == 1})
          3'b110:  rq_isa[0] = 1'b1;                                // R1
          3'b101:  rq_isa[8] = 1'b1;
          default: begin
            if (int'(rt(t)) < NI && tmr_cap[t*32 + int'(rt(t))])    // R4
              rq_io[rt(t)] = 1'b1;                                  // R3
            else bad = 1'b1;                                        // R5
          end
        endcase
      end
    end
    rq_isa = rq_isa | p_isa;   // R9 held requests
    rq_io  = rq_io  | p_io;
    p_isa  = rq_isa & e_isa;
    p_io   = rq_io  & e_io;
    e_isa  = rq_isa & ~e_isa;
    e_io   = rq_io  & ~e_io;
    e_err  = bad ? 1'b1 : (err_clr ? 1'b0 : e_err);                 // R10
    e_mute = legacy_en && tmr_armed[0];                             // R2
  endtask

  task automatic compare(input string tag);
    n_chk++;
    if (isa_pulse !== e_isa) begin
      n_bad++; $display("FAIL %s isa_pulse actual=%h expected=%h", tag, isa_pulse, e_isa);
    end
    n_chk++;
    if (ioin_pulse !== e_io) begin
      n_bad++; $display("FAIL %s ioin_pulse actual=%h expected=%h", tag, ioin_pulse, e_io);
    end
    n_chk++;
    if (route_err !== e_err) begin
      n_bad++; $display("FAIL %s route_err actual=%b expected=%b", tag, route_err, e_err);
    end
    n_chk++;
    if (pit_ch0_mute !== e_mute) begin
      n_bad++; $display("FAIL %s pit_ch0_mute actual=%b expected=%b", tag, pit_ch0_mute, e_mute);
    end
  endtask

  // inputs are set at a negedge; model advances; compare at next negedge
  task automatic cycle(input string tag);
    model_step();
    @(negedge clk);
    compare(tag);
    fire    = '0;
    err_clr = 1'b0;
  endtask

  task automatic set_t(input int t, input logic [4:0] r, input logic [31:0] c,
                       input logic a, input logic l);
    tmr_route[t*RW +: RW] = r;
    tmr_cap[t*32 +: 32]   = c;
    tmr_armed[t]          = a;
    tmr_level[t]          = l;
  endtask

  initial begin
    void'($urandom(32'd20071121));
    rst_n = 1'b0; legacy_en = 1'b0; fire = '0; err_clr = 1'b0;
    tmr_route = '0; tmr_cap = '0; tmr_armed = '0; tmr_level = '0;
    e_isa = '0; e_io = '0; p_isa = '0; p_io = '0; e_mute = 1'b0; e_err = 1'b0;

    // R11: reset with stimulus that would otherwise produce activity
    for (int t = 0; t < NT; t++) set_t(t, 5'd20, 32'hFFFF_FFFF, 1'b1, 1'b0);
    legacy_en = 1'b1; fire = '1;
    repeat (3) @(negedge clk);
    compare("R11");
    fire = '0; legacy_en = 1'b0;
    for (int t = 0; t < NT; t++) set_t(t, 5'd20, irq_route_pkg::CAP_RESET, 1'b1, 1'b0);
    rst_n = 1'b1;
    cycle("R11");

    // R1 + R2: legacy mode, timers 0 and 1 to fixed ISA lines, timer 2 routed
    legacy_en = 1'b1; set_t(0, 5'd21, irq_route_pkg::CAP_RESET, 1'b1, 1'b0);
    set_t(1, 5'd22, irq_route_pkg::CAP_RESET, 1'b1, 1'b0);
    set_t(2, 5'd23, irq_route_pkg::CAP_RESET, 1'b1, 1'b0);
    fire = 3'b111; cycle("R1");
    cycle("R2");
    tmr_armed[0] = 1'b0; cycle("R2");
    legacy_en = 1'b0; tmr_armed[0] = 1'b1; cycle("R2");

    // R3: configurable path, each of the permitted inputs
    for (int r = 20; r < 24; r++) begin
      set_t(1, 5'(r), irq_route_pkg::CAP_RESET, 1'b1, 1'b0);
      fire = 3'b010; cycle("R3"); cycle("R3");
    end

    // R4/R5: mask bit clear, then route 25 with all-ones mask
    set_t(0, 5'd5, irq_route_pkg::CAP_RESET, 1'b1, 1'b0);
    fire = 3'b001; cycle("R4"); cycle("R5");
    err_clr = 1'b1; cycle("R10");
    set_t(0, 5'd25, 32'hFFFF_FFFF, 1'b1, 1'b0);
    fire = 3'b001; cycle("R4"); cycle("R5");
    // R10: set and clear in the same cycle keep the flag
    fire = 3'b001; err_clr = 1'b1; cycle("R10");
    cycle("R10");
    err_clr = 1'b1; cycle("R10");

    // R6: level type armed but idle, then firing
    set_t(2, 5'd20, irq_route_pkg::CAP_RESET, 1'b1, 1'b1);
    cycle("R6");
    err_clr = 1'b1; fire = 3'b100; cycle("R6");
    set_t(2, 5'd20, irq_route_pkg::CAP_RESET, 1'b0, 1'b1);
    err_clr = 1'b1; cycle("R6");

    // R7: disarmed fire, legal and illegal routes
    set_t(0, 5'd21, irq_route_pkg::CAP_RESET, 1'b0, 1'b0);
    set_t(1, 5'd3,  irq_route_pkg::CAP_RESET, 1'b0, 1'b0);
    fire = 3'b011; cycle("R7"); cycle("R7");

    // R8: simultaneous fires, distinct then shared targets
    set_t(0, 5'd20, irq_route_pkg::CAP_RESET, 1'b1, 1'b0);
    set_t(1, 5'd21, irq_route_pkg::CAP_RESET, 1'b1, 1'b0);
    set_t(2, 5'd23, irq_route_pkg::CAP_RESET, 1'b1, 1'b0);
    fire = 3'b111; cycle("R8"); cycle("R8");
    set_t(1, 5'd20, irq_route_pkg::CAP_RESET, 1'b1, 1'b0);
    set_t(2, 5'd20, irq_route_pkg::CAP_RESET, 1'b1, 1'b0);
    fire = 3'b111; cycle("R8"); cycle("R8");

    // R9: back-to-back fires on one line give pulse, gap, pulse
    fire = 3'b001; cycle("R9");
    fire = 3'b001; cycle("R9");
    cycle("R9"); cycle("R9");
    legacy_en = 1'b1;
    for (int k = 0; k < 4; k++) begin fire = 3'b001; cycle("R9"); end
    cycle("R9"); legacy_en = 1'b0;

    // mixed random traffic
    for (int k = 0; k < 3000; k++) begin
      legacy_en = ($urandom % 3) == 0;
      for (int t = 0; t < NT; t++)
        set_t(t,
              (($urandom % 4) == 0) ? 5'($urandom % 32) : 5'(20 + $urandom % 4),
              (($urandom % 4) == 0) ? 32'($urandom) : irq_route_pkg::CAP_RESET,
              ($urandom % 8) != 0, ($urandom % 20) == 0);
      fire    = 3'($urandom % 8);
      err_clr = ($urandom % 6) == 0;
      cycle("RND");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule